// File: doc/BRIEF.md
# Framebuffer Host Access Port

This block sits between a processor's register bus and a 32-bit-wide video memory. The processor sees eight word slots selected by a 3-bit offset. Two of the slots hold address latches: one for reads and one for writes. A third slot is the data window into video memory. Reading the data window fetches the word that the read latch points to and then advances only the read latch. Writing the data window stores a word where the write latch points and then advances only the write latch. A read-modify-write of one word therefore needs both latches loaded with the same address.

Video memory is a flat array of 32000 words, with one step of address per word. Each word carries eight 4-bit pixels, and a display line of 640 pixels takes 80 words, so line n begins at word 80·n. The palette select and palette data slots are not stored here. Writes to them come out as one-cycle strobes together with the write data, for the palette logic next door. The control slot returns a status word supplied by the video timing logic. All read data appears on the bus one cycle after the read strobe.

Top module: `vid_host_bridge`

## Requirements
- R1: After reset both latches are 0, `busRdata` is 0, and neither memory enable is asserted.
- R2: A bus write to offset 0 loads the read latch, and a write to offset 1 loads the write latch, each from `busWdata[14:0]`. Reading offset 0 or offset 1 returns that latch zero-extended to 32 bits.
- R3: A bus write to offset 2 asserts `memWrEn` in the same cycle, with `memWrAddr` equal to the write latch and `memWrData` equal to `busWdata`. After that cycle the write latch is one higher.
- R4: A bus read of offset 2 asserts `memRdEn` in the same cycle, with `memRdAddr` equal to the read latch. On the next cycle `busRdata` equals `memRdData`. After that cycle the read latch is one higher.
- R5: An access to offset 2 in one direction leaves the latch of the other direction unchanged.
- R6: A latch that holds 31999 and is advanced by an access to offset 2 becomes 0.
- R7: A bus write to offset 3 pulses `palSelWr`, and a write to offset 4 pulses `palDataWr`, for one cycle, with `palWrData` equal to `busWdata`. A read of offset 3 or offset 4 returns 0.
- R8: A bus read of offset 5 returns, on the next cycle, the value `ctlStatus` had in the strobe cycle.
- R9: `busRdata` is 0 in any cycle that does not follow a read strobe. Offsets 6 and 7 read as 0, and writing them asserts no strobe and changes no latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after `busRd` |
| memRdEn | output | 1 | Video memory read enable |
| memRdAddr | output | 15 | Video memory read word address |
| memRdData | input | 32 | Video memory read data, one cycle after `memRdEn` |
| memWrEn | output | 1 | Video memory write enable |
| memWrAddr | output | 15 | Video memory write word address |
| memWrData | output | 32 | Video memory write data |
| palSelWr | output | 1 | Palette slot select write strobe |
| palDataWr | output | 1 | Palette colour write strobe |
| palWrData | output | 32 | Data for the palette strobes |
| ctlStatus | input | 32 | Status word returned at offset 5 |

## Verification
A wrong latch value is visible on `memRdAddr` or `memWrAddr` at the next access to offset 2. It can also be read back at offset 0 or 1 one cycle after the strobe. If a latch advances when it should not, or misses an advance, every following streamed access lands on a shifted word, so the error stays visible until that latch is reloaded. A wrong read-source select shows up at once, as wrong or non-zero `busRdata` on the cycle after the strobe.

// File: rtl/vhb_pkg.sv
package vhb_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_RDA  = 3'd1,
    SRC_WRA  = 3'd2,
    SRC_MEM  = 3'd3,
    SRC_CTL  = 3'd4
  } rdSrc_e;

  typedef struct packed {
    logic   ldRd;
    logic   ldWr;
    logic   ioRd;
    logic   ioWr;
    logic   palSel;
    logic   palData;
    logic   rdAny;
    rdSrc_e rdSrc;
  } strobes_t;

endpackage

// File: rtl/vhb_ctrl.sv
module vhb_ctrl
  import vhb_pkg::*;
#(
  parameter int OFF_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OFF_W-1:0] busAddr,
  input  logic             busWr,
  input  logic             busRd,
  output strobes_t         stb
);

  localparam logic [OFF_W-1:0] OFF_RDA = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_WRA = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_IO  = OFF_W'(2);
  localparam logic [OFF_W-1:0] OFF_PSL = OFF_W'(3);
  localparam logic [OFF_W-1:0] OFF_PDT = OFF_W'(4);
  localparam logic [OFF_W-1:0] OFF_CTL = OFF_W'(5);

  always_comb begin
    stb         = '0;
    stb.rdSrc   = SRC_NONE;
    stb.ldRd    = busWr && (busAddr == OFF_RDA);
    stb.ldWr    = busWr && (busAddr == OFF_WRA);
    stb.ioWr    = busWr && (busAddr == OFF_IO);
    stb.palSel  = busWr && (busAddr == OFF_PSL);
    stb.palData = busWr && (busAddr == OFF_PDT);
    stb.ioRd    = busRd && (busAddr == OFF_IO);
    stb.rdAny   = busRd;
    if (busRd) begin
      case (busAddr)
        OFF_RDA: stb.rdSrc = SRC_RDA;
        OFF_WRA: stb.rdSrc = SRC_WRA;
        OFF_IO:  stb.rdSrc = SRC_MEM;
        OFF_CTL: stb.rdSrc = SRC_CTL;
        default: stb.rdSrc = SRC_NONE;
      endcase
    end
  end

  // R9
  write_strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldRd, stb.ldWr, stb.ioWr, stb.palSel, stb.palData}));

  // R7
  pal_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.palSel || stb.palData) |-> busWr);

endmodule

// File: rtl/vhb_datapath.sv
module vhb_datapath
  import vhb_pkg::*;
#(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 32,
  parameter int WORD_LIMIT = 32000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] ctlStatus,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] rdLatch,
  output logic [ADDR_W-1:0] wrLatch
);

  localparam logic [ADDR_W-1:0] LAST_WORD = ADDR_W'(WORD_LIMIT - 1);

  logic [DATA_W-1:0] holdQ;
  rdSrc_e            srcQ;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a);
    return (a == LAST_WORD) ? '0 : a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdLatch <= '0;
      wrLatch <= '0;
    end else begin
      if (stb.ldRd)      rdLatch <= busWdata[ADDR_W-1:0];
      else if (stb.ioRd) rdLatch <= stepAddr(rdLatch);
      if (stb.ldWr)      wrLatch <= busWdata[ADDR_W-1:0];
      else if (stb.ioWr) wrLatch <= stepAddr(wrLatch);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ  <= SRC_NONE;
      holdQ <= '0;
    end else begin
      srcQ <= stb.rdSrc;
      case (stb.rdSrc)
        SRC_RDA: holdQ <= DATA_W'(rdLatch);
        SRC_WRA: holdQ <= DATA_W'(wrLatch);
        SRC_CTL: holdQ <= ctlStatus;
        default: holdQ <= '0;
      endcase
    end
  end

  assign busRdata = (srcQ == SRC_MEM) ? memRdData : holdQ;

  // R4
  rd_latch_advances_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ioRd && !stb.ldRd) |=> (rdLatch != $past(rdLatch)));

  // R5
  rd_latch_kept_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ioWr && !stb.ioRd && !stb.ldRd) |=> $stable(rdLatch));

  // R5
  wr_latch_kept_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ioRd && !stb.ioWr && !stb.ldWr) |=> $stable(wrLatch));

  // R6
  wr_latch_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ioWr && !stb.ldWr && wrLatch == LAST_WORD) |=> (wrLatch == '0));

  // R9
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdAny |=> (busRdata == '0));

endmodule

// File: rtl/vid_host_bridge.sv
module vid_host_bridge
  import vhb_pkg::*;
#(
  parameter int OFF_W      = 3,
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 32,
  parameter int WORD_LIMIT = 32000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFF_W-1:0]  busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              palSelWr,
  output logic              palDataWr,
  output logic [DATA_W-1:0] palWrData,
  input  logic [DATA_W-1:0] ctlStatus
);

  strobes_t          stb;
  logic [ADDR_W-1:0] rdLatch;
  logic [ADDR_W-1:0] wrLatch;

  vhb_ctrl #(.OFF_W(OFF_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  vhb_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .WORD_LIMIT (WORD_LIMIT)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .ctlStatus (ctlStatus),
    .memRdData (memRdData),
    .busRdata  (busRdata),
    .rdLatch   (rdLatch),
    .wrLatch   (wrLatch)
  );

  assign memRdEn   = stb.ioRd;
  assign memRdAddr = rdLatch;
  assign memWrEn   = stb.ioWr;
  assign memWrAddr = wrLatch;
  assign memWrData = busWdata;
  assign palSelWr  = stb.palSel;
  assign palDataWr = stb.palData;
  assign palWrData = busWdata;

  // R3
  mem_write_follows_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (busWr && memWrData == busWdata));

  // R4
  mem_read_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> busRd);

  // R4
  mem_read_data_passed_chk: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (busRdata == memRdData));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (busRdata == '0));

endmodule

// File: tb/vid_host_bridge_test.sv
module vid_host_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 32000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        memRdEn;
  logic [14:0] memRdAddr;
  logic [31:0] memRdData = '0;
  logic        memWrEn;
  logic [14:0] memWrAddr;
  logic [31:0] memWrData;
  logic        palSelWr;
  logic        palDataWr;
  logic [31:0] palWrData;
  logic [31:0] ctlStatus = '0;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] model  [int];
  logic [31:0] expMem [int];
  logic [14:0] expRd = '0;
  logic [14:0] expWr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_host_bridge uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .memRdEn(memRdEn),
    .memRdAddr(memRdAddr), .memRdData(memRdData), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .palSelWr(palSelWr),
    .palDataWr(palDataWr), .palWrData(palWrData), .ctlStatus(ctlStatus)
  );

  // video memory model: read sees the old contents, then the write lands
  always @(posedge clk) begin
    if (memRdEn) memRdData <= model.exists(int'(memRdAddr)) ? model[int'(memRdAddr)] : 32'd0;
    if (memWrEn) model[int'(memWrAddr)] = memWrData;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [14:0] step(input logic [14:0] a);
    return (a == 15'(LIMIT - 1)) ? 15'd0 : a + 15'd1;
  endfunction

  // one bus cycle, started at a falling edge; ends at the next falling edge
  task automatic op(input int off, input bit w, input bit r, input logic [31:0] wd);
    logic [31:0] expVal;
    logic [14:0] nRd;
    logic [14:0] nWr;
    busAddr   = 3'(off);
    busWr     = w;
    busRd     = r;
    busWdata  = wd;
    ctlStatus = $urandom;
    #1;
    chk("R4 memRdEn", 32'(memRdEn), 32'(r && off == 2));
    if (r && off == 2) chk("R4 memRdAddr", 32'(memRdAddr), 32'(expRd));
    chk("R3 memWrEn", 32'(memWrEn), 32'(w && off == 2));
    if (w && off == 2) begin
      chk("R3 memWrAddr", 32'(memWrAddr), 32'(expWr));
      chk("R3 memWrData", memWrData, wd);
    end
    chk("R7 palSelWr", 32'(palSelWr), 32'(w && off == 3));
    chk("R7 palDataWr", 32'(palDataWr), 32'(w && off == 4));
    if (w && (off == 3 || off == 4)) chk("R7 palWrData", palWrData, wd);
    expVal = '0;
    if (r) begin
      case (off)
        0: expVal = 32'(expRd);
        1: expVal = 32'(expWr);
        2: expVal = expMem.exists(int'(expRd)) ? expMem[int'(expRd)] : 32'd0;
        5: expVal = ctlStatus;
        default: expVal = '0;
      endcase
    end
    if (w && off == 2) expMem[int'(expWr)] = wd;
    nRd = expRd;
    nWr = expWr;
    if (r && off == 2) nRd = step(expRd);
    if (w && off == 2) nWr = step(expWr);
    if (w && off == 0) nRd = wd[14:0];
    if (w && off == 1) nWr = wd[14:0];
    @(negedge clk);
    if (!r)            chk("R9 idle busRdata", busRdata, 32'd0);
    else if (off == 2) chk("R4 read data", busRdata, expVal);
    else if (off == 5) chk("R8 status read", busRdata, expVal);
    else if (off <= 1) chk("R2 latch read", busRdata, expVal);
    else if (off <= 4) chk("R7 palette read", busRdata, expVal);
    else               chk("R9 unused read", busRdata, expVal);
    expRd = nRd;
    expWr = nWr;
    busWr = 1'b0;
    busRd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd7001));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 busRdata", busRdata, 32'd0);
    chk("R1 memRdEn", 32'(memRdEn), 32'd0);
    chk("R1 memWrEn", 32'(memWrEn), 32'd0);
    @(negedge clk);
    op(0, 0, 1, 0);
    op(1, 0, 1, 0);

    // R2 load and read back both latches
    op(0, 1, 0, 32'hFFFF_0123);
    op(1, 1, 0, 32'h0000_00A0);
    op(0, 0, 1, 0);
    op(1, 0, 1, 0);

    // R3/R4/R5 streamed write then read of one line
    for (int i = 0; i < 80; i++) op(2, 1, 0, $urandom);
    op(0, 1, 0, 32'd160);
    op(1, 0, 1, 0);
    for (int i = 0; i < 80; i++) op(2, 0, 1, 0);
    op(1, 0, 1, 0);

    // R6 wrap of both latches
    op(1, 1, 0, 32'd31998);
    op(2, 1, 0, 32'hDEAD_0001);
    op(2, 1, 0, 32'hDEAD_0002);
    op(2, 1, 0, 32'hDEAD_0003);
    op(1, 0, 1, 0);
    op(0, 1, 0, 32'd31998);
    op(2, 0, 1, 0);
    op(2, 0, 1, 0);
    op(2, 0, 1, 0);
    op(0, 0, 1, 0);

    // R7 palette strobes and zero reads
    op(3, 1, 0, 32'h0000_000C);
    op(4, 1, 0, 32'h0000_0ABC);
    op(3, 0, 1, 0);
    op(4, 0, 1, 0);

    // R8 status
    op(5, 0, 1, 0);
    op(5, 0, 1, 0);

    // R9 unused offsets
    op(6, 1, 0, 32'h1234_5678);
    op(7, 1, 0, 32'h0000_7FFF);
    op(6, 0, 1, 0);
    op(7, 0, 1, 0);
    op(0, 0, 1, 0);
    op(1, 0, 1, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      int off;
      bit w;
      bit r;
      logic [31:0] wd;
      off = int'($urandom_range(0, 7));
      if ($urandom_range(0, 2) != 0) off = 2;
      w = 1'($urandom);
      r = 1'($urandom);
      wd = $urandom;
      if (off <= 1 && w) begin
        if ($urandom_range(0, 3) == 0) wd = 32'(LIMIT - 1 - int'($urandom_range(0, 3)));
        else wd = 32'($urandom_range(0, LIMIT - 1));
      end
      op(off, w, r, wd);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule